// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address for every beat of an SDRAM read or write burst. When a burst is launched it captures the starting column, the length code and the ordering bit taken from the mode register image. It then presents one column per beat, advancing each time the consumer accepts the current beat. A flag marks the final beat of a finite burst. A stop request cuts a burst short at any length.

Finite bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that size. The beat order within the block is either sequential (wrapping) or interleaved. Full-page mode runs sequentially across the whole 512-column row and wraps from the top column back to column 0. It continues until a stop request or a new start ends it. A new start may coincide with the final beat of the previous burst, so bursts can run back to back with no idle cycle between them. All outputs are registered.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and after it is released, `valid_o` and `last_o` are 0 and `col_o` is 0 until the first start.
- R2: The cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals the starting column (beat 0). The length code and the ordering bit are captured only at a start, and changes to them during a burst have no effect on that burst.
- R3: The 3-bit length code selects the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. The codes 100, 101 and 110 behave as 1 beat. A finite burst ends, with `valid_o` low, in the cycle after its final beat is accepted.
- R4: With the ordering bit at 0 (sequential), beat k of a burst of length BL has low log2(BL) bits equal to (start + k) mod BL. The upper bits equal those of the starting column.
- R5: With the ordering bit at 1 (interleaved), beat k of a finite burst has low log2(BL) bits equal to the start's low bits XOR k. The upper bits are unchanged.
- R6: In full-page mode the ordering bit is ignored. Beat k is (start + k) mod 512, so the address wraps from 511 to 0, and `last_o` is never asserted.
- R7: `last_o` is 1 exactly while the final beat of a finite burst is presented, and only while `valid_o` is 1.
- R8: While `adv_i` is low and no start or stop is sampled, the current beat is held unchanged. `adv_i` has no effect while `valid_o` is 0.
- R9: A stop sampled while a burst is valid ends it at any length, including full page: `valid_o` is 0 the next cycle. A start in the same cycle takes priority over the stop.
- R10: A start sampled in any cycle of a burst, including the cycle its final beat is accepted, makes beat 0 of the new burst appear the next cycle with no idle beat in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch a burst at `start_col_i` |
| start_col_i | input | 9 | Starting column of the burst |
| len_code_i | input | 3 | Burst length code from the mode image |
| order_ilv_i | input | 1 | Beat ordering: 0 sequential, 1 interleaved |
| adv_i | input | 1 | Current beat accepted, move to the next |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a finite burst |

## Verification
The bench builds the block with its default 9-bit column and 3-bit length code. At that size, a full-page burst started near the top of the row reaches the wrap from column 511 to column 0 within a few beats. Every length code, including the reserved ones, can be tried under both ordering bits. A starting column with nonzero low bits shows both the wrap inside an aligned block and the XOR ordering. Stalls, stops, start/stop collisions and back-to-back starts are compared beat by beat against a behavioural model.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    BLEN_1    = 3'b000,
    BLEN_2    = 3'b001,
    BLEN_4    = 3'b010,
    BLEN_8    = 3'b011,
    BLEN_PAGE = 3'b111
  } blen_code_e;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } beat_order_e;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic [LEN_W-1:0] code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);
  import burst_pkg::*;

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  always_comb begin
    page_o = 1'b0;
    mask_o = '0;
    case (blen_code_e'(code_i))
      BLEN_2:    mask_o = (ONE << 1) - ONE;
      BLEN_4:    mask_o = (ONE << 2) - ONE;
      BLEN_8:    mask_o = (ONE << 3) - ONE;
      BLEN_PAGE: begin
        mask_o = '1;
        page_o = 1'b1;
      end
      default:   mask_o = '0;
    endcase
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             page_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (ilv_i && !page_i) low = base_i ^ beat_i;
    else                  low = base_i + beat_i;
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             order_ilv_i,
  input  logic             adv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] base_q, base_n;
  logic [COL_W-1:0] beat_q, beat_n;
  logic [COL_W-1:0] mask_q, mask_n, mask_dec;
  logic             ilv_q, ilv_n;
  logic             page_q, page_n, page_dec;
  logic             valid_n, last_n;
  logic [COL_W-1:0] col_n;

  burst_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W)) u_dec (
    .code_i (len_code_i),
    .mask_o (mask_dec),
    .page_o (page_dec)
  );

  always_comb begin
    base_n  = base_q;
    beat_n  = beat_q;
    mask_n  = mask_q;
    ilv_n   = ilv_q;
    page_n  = page_q;
    valid_n = valid_o;
    if (start_i) begin
      base_n  = start_col_i;
      beat_n  = '0;
      mask_n  = mask_dec;
      ilv_n   = order_ilv_i;
      page_n  = page_dec;
      valid_n = 1'b1;
    end else if (valid_o && stop_i) begin
      valid_n = 1'b0;
    end else if (valid_o && adv_i) begin
      if (last_o) valid_n = 1'b0;
      else        beat_n  = beat_q + COL_W'(1);
    end
    last_n = valid_n && !page_n && (beat_n == mask_n);
  end

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base_n),
    .beat_i (beat_n),
    .mask_i (mask_n),
    .ilv_i  (ilv_n),
    .page_i (page_n),
    .col_o  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      col_o   <= '0;
    end else begin
      base_q  <= base_n;
      beat_q  <= beat_n;
      mask_q  <= mask_n;
      ilv_q   <= ilv_n;
      page_q  <= page_n;
      valid_o <= valid_n;
      last_o  <= last_n;
      col_o   <= col_n;
    end
  end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [LEN_W-1:0] len_code_i,
  input logic             order_ilv_i,
  input logic             adv_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!valid_o && !last_o)); // R1
  AST_START_BEAT0: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R2
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !adv_i && !stop_i && !start_i) |=> (valid_o && $stable(col_o) && $stable(last_o))); // R8
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (valid_o && stop_i && !start_i) |=> !valid_o); // R9
  AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && adv_i && !start_i && !stop_i) |=> !valid_o); // R3
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start_i) |=> !valid_o); // R8
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       order_ilv_i = 1'b0;
  logic       adv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  int m_valid = 0, m_base = 0, m_k = 0, m_bl = 1, m_ilv = 0, m_page = 0;

  always #10 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .order_ilv_i(order_ilv_i), .adv_i(adv_i),
    .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int exp_col();
    int m;
    int low;
    if (m_page != 0) return (m_base + m_k) % 512;
    m = m_bl - 1;
    if (m_ilv != 0) low = (m_base ^ m_k) & m;
    else            low = (m_base + m_k) & m;
    return (m_base & ~m & 511) | low;
  endfunction

  function automatic int exp_last();
    return (m_valid != 0 && m_page == 0 && m_k == m_bl - 1) ? 1 : 0;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_valid = 0; m_base = 0; m_k = 0;
    end else if (start_i) begin
      m_valid = 1; m_base = start_col_i; m_k = 0; m_ilv = order_ilv_i; m_page = 0;
      case (len_code_i)
        3'b001: m_bl = 2;
        3'b010: m_bl = 4;
        3'b011: m_bl = 8;
        3'b111: begin m_bl = 512; m_page = 1; m_ilv = 0; end
        default: m_bl = 1;
      endcase
    end else if (m_valid != 0 && stop_i) begin
      m_valid = 0;
    end else if (m_valid != 0 && adv_i) begin
      if (exp_last() != 0) m_valid = 0;
      else m_k = (m_k + 1) % 512;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("valid", int'(valid_o), m_valid);
    check("last", int'(last_o), exp_last());
    if (m_valid != 0) check("col", int'(col_o), exp_col());
    start_i = 1'b0;
    stop_i  = 1'b0;
  endtask

  task automatic launch(logic [2:0] len, logic ilv, logic [8:0] col);
    start_i = 1'b1; len_code_i = len; order_ilv_i = ilv; start_col_i = col;
  endtask

  task automatic run_all_beats(logic [2:0] len, logic ilv, logic [8:0] col, int beats);
    launch(len, ilv, col);
    adv_i = 1'b0;
    step();
    adv_i = 1'b1;
    for (int i = 0; i < beats + 1; i++) step();
    adv_i = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    tag = "R1";
    step(); step();
    check("col at reset", int'(col_o), 0);
    rst = 1'b0;
    step();

    tag = "R4";
    run_all_beats(3'b011, 1'b0, 9'h1A5, 8);
    run_all_beats(3'b010, 1'b0, 9'h0C6, 4);
    run_all_beats(3'b001, 1'b0, 9'h0C7, 2);

    tag = "R5";
    run_all_beats(3'b011, 1'b1, 9'h1A5, 8);
    run_all_beats(3'b010, 1'b1, 9'h03F, 4);
    run_all_beats(3'b001, 1'b1, 9'h011, 2);

    tag = "R3";
    run_all_beats(3'b000, 1'b0, 9'h155, 1);
    run_all_beats(3'b101, 1'b1, 9'h0AA, 1);
    run_all_beats(3'b110, 1'b0, 9'h0AB, 1);
    run_all_beats(3'b100, 1'b0, 9'h001, 1);

    tag = "R7";
    run_all_beats(3'b011, 1'b0, 9'h007, 8);

    tag = "R6";
    launch(3'b111, 1'b1, 9'h1FB);
    step();
    adv_i = 1'b1;
    for (int i = 0; i < 12; i++) step();
    tag = "R9";
    stop_i = 1'b1;
    step();
    adv_i = 1'b0;
    step();

    tag = "R8";
    adv_i = 1'b1;
    step();
    adv_i = 1'b0;
    launch(3'b011, 1'b0, 9'h0F2);
    step();
    for (int i = 0; i < 20; i++) begin
      adv_i = (i % 3 == 1);
      step();
    end
    adv_i = 1'b1;
    for (int i = 0; i < 8; i++) step();
    adv_i = 1'b0;

    tag = "R2";
    launch(3'b010, 1'b1, 9'h105);
    step();
    len_code_i = 3'b111; order_ilv_i = 1'b0; start_col_i = 9'h000;
    adv_i = 1'b1;
    for (int i = 0; i < 5; i++) step();
    adv_i = 1'b0;

    tag = "R9";
    launch(3'b011, 1'b1, 9'h033);
    step();
    adv_i = 1'b1; step(); step();
    stop_i = 1'b1; step();
    step();
    launch(3'b011, 1'b0, 9'h044);
    step();
    stop_i = 1'b1;
    launch(3'b001, 1'b0, 9'h1FF);
    step();
    step(); step(); step();
    adv_i = 1'b0;

    tag = "R10";
    launch(3'b001, 1'b0, 9'h020);
    step();
    adv_i = 1'b1;
    step();
    launch(3'b010, 1'b1, 9'h0A6);
    step();
    step(); step(); step();
    launch(3'b000, 1'b0, 9'h123);
    step();
    launch(3'b000, 1'b0, 9'h124);
    step();
    step();
    adv_i = 1'b0;
    launch(3'b011, 1'b0, 9'h0F0);
    step();
    adv_i = 1'b1; step();
    launch(3'b111, 1'b0, 9'h1FE);
    step(); step(); step(); step();
    stop_i = 1'b1; step();
    adv_i = 1'b0;
    step();

    report();
  end
endmodule